// File: doc/BRIEF.md
# Reference Validity Monitor

This block watches one of two incoming reference clocks and decides, on a free-running local clock, whether that reference is fit to steer a downstream oscillator. A select input picks the reference. A ratio code sets how many reference rising edges make up one measurement unit. Each unit is timed in local-clock cycles, and its length must fall inside a narrow window around a nominal count. The block drives one active-high flag: high means the selected reference is usable and low means it has failed.

Failure is reported quickly. One out-of-window unit drops the flag, and so does a silence of two nominal units with no unit completing. Recovery is slow on purpose. The flag rises again only after a fixed run of consecutive in-window units, so a marginal reference cannot make the flag chatter. Any change of the reference select or of the ratio code throws away the current measurement and restarts the recovery run. The reference inputs are treated as asynchronous and are synchronized inside the block. The select and ratio inputs are taken as synchronous to the local clock.

Top module: `ref_valid_monitor`

## Requirements
- R1: When `ref_pick` is 1 the block monitors `ref_a`. When it is 0 the block monitors `ref_b`. Activity or silence on the reference that is not selected has no effect on `valid_o`.
- R2: `valid_o` is high only while the selected reference is judged usable. It is low while `rst` is high and stays low after reset until a full recovery run has completed.
- R3: With ratio code c (0 to 3), one measurement unit is n = 2^c rising edges of the selected reference. The nominal unit length is NOM_CYC local cycles (default 64).
- R4: A unit whose length in local cycles lies within NOM_CYC-TOL_CYC to NOM_CYC+TOL_CYC inclusive (default 60 to 68) is good. A longer or shorter unit is bad. A bad unit drops `valid_o`, so a drifted reference is flagged within two nominal units.
- R5: If no unit completes within TIMEOUT_UNITS*NOM_CYC local cycles (default 128) after the last one, `valid_o` falls. With the defaults this happens no later than 2*NOM_CYC plus a few cycles after the last reference edge.
- R6: `valid_o` rises only after GOOD_UNITS (default 12) consecutive good units. The first unit boundary after a reset, a restart or a timeout only arms the measurement and is not judged. Recovery then happens without any outside action.
- R7: A change of `ref_pick` or of `ratio_code` clears `valid_o` on the next cycle and starts a new recovery run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | 1 | First reference clock, asynchronous |
| ref_b | input | 1 | Second reference clock, asynchronous |
| ref_pick | input | 1 | Reference select: 1 picks ref_a, 0 picks ref_b |
| ratio_code | input | RSEL_W | Edges per unit, n = 2^code |
| valid_o | output | 1 | High when the selected reference is usable |

## Verification
A corrupted recovery count shows up at the ports as the flag rising one or more units too early or too late. Sampling at about 11 and about 15 nominal units after a fresh start catches this. A wrong window bound or divider shows up as the flag holding the wrong level about 20 units after a constant-period reference is applied, and reference periods on both sides of each window edge expose this. A broken timeout counter shows as the flag staying high, or falling early, around 128 cycles after the reference is stopped. Lost restart logic shows as the flag staying high a few cycles after the select or the ratio is changed.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    // Outcome of one measurement unit, produced by the period judge.
    typedef enum logic [1:0] {
        VD_NONE = 2'd0,
        VD_GOOD = 2'd1,
        VD_BAD  = 2'd2
    } verdict_e;

    // Front-end outputs handed to the period judge.
    typedef struct packed {
        logic restart;
        logic tick;
    } front_t;

    // Inclusive window test on a measured unit length.
    function automatic logic in_window(input int unsigned len,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (len >= lo) && (len <= hi);
    endfunction

endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rvm_front.sv
module rvm_front import rvm_pkg::*; #(
    parameter int RSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ref_s,
    input  logic              ref_pick,
    input  logic [RSEL_W-1:0] ratio_code,
    output front_t            front
);
    localparam int DIV_W = (1 << RSEL_W) - 1;

    logic              pick_q;
    logic [RSEL_W-1:0] code_q;
    logic              cur, prev;
    logic              rise;
    logic [DIV_W-1:0]  div_cnt;
    logic [DIV_W-1:0]  last_idx;
    logic              restart;

    // Select and ratio are local-domain inputs; a change restarts everything.
    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= ref_pick;
            code_q <= ratio_code;
        end else begin
            pick_q <= ref_pick;
            code_q <= ratio_code;
        end
    end

    assign restart = (ref_pick != pick_q) || (ratio_code != code_q);
    assign cur     = ref_pick ? ref_s[0] : ref_s[1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= cur;
    end

    assign rise     = cur && !prev && !restart;
    assign last_idx = DIV_W'((32'd1 << ratio_code) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst || restart)    div_cnt <= '0;
        else if (rise) begin
            if (div_cnt == last_idx) div_cnt <= '0;
            else                     div_cnt <= div_cnt + 1'b1;
        end
    end

    assign front.restart = restart;
    assign front.tick    = rise && (div_cnt == last_idx);
endmodule

// File: rtl/rvm_period.sv
module rvm_period import rvm_pkg::*; #(
    parameter int NOM_CYC       = 64,
    parameter int TOL_CYC       = 4,
    parameter int TIMEOUT_UNITS = 2,
    localparam int TIMEOUT_CYC  = TIMEOUT_UNITS * NOM_CYC,
    localparam int PW           = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  front_t        front,
    output verdict_e      verdict,
    output logic [PW-1:0] period_cnt
);
    localparam int LO_CYC = NOM_CYC - TOL_CYC;
    localparam int HI_CYC = NOM_CYC + TOL_CYC;

    logic          armed;
    logic [PW:0]   elapsed;

    assign elapsed = {1'b0, period_cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || front.restart) begin
            period_cnt <= '0;
            armed      <= 1'b0;
            verdict    <= VD_NONE;
        end else begin
            verdict <= VD_NONE;
            if (front.tick) begin
                if (armed)
                    verdict <= in_window(int'(elapsed), LO_CYC, HI_CYC) ? VD_GOOD : VD_BAD;
                armed      <= 1'b1;
                period_cnt <= '0;
            end else if (armed) begin
                if (int'(elapsed) >= TIMEOUT_CYC) begin
                    verdict    <= VD_BAD;
                    armed      <= 1'b0;
                    period_cnt <= '0;
                end else begin
                    period_cnt <= period_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rvm_recovery.sv
module rvm_recovery import rvm_pkg::*; #(
    parameter int GOOD_UNITS = 12,
    localparam int GW        = $clog2(GOOD_UNITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  verdict_e      verdict,
    output logic [GW-1:0] good_run,
    output logic          valid
);
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            good_run <= '0;
            valid    <= 1'b0;
        end else begin
            case (verdict)
                VD_BAD: begin
                    good_run <= '0;
                    valid    <= 1'b0;
                end
                VD_GOOD: begin
                    if (int'(good_run) >= GOOD_UNITS - 1) begin
                        good_run <= GW'(GOOD_UNITS);
                        valid    <= 1'b1;
                    end else begin
                        good_run <= good_run + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ref_valid_monitor.sv
module ref_valid_monitor import rvm_pkg::*; #(
    parameter int RSEL_W        = 2,
    parameter int NOM_CYC       = 64,
    parameter int TOL_CYC       = 4,
    parameter int TIMEOUT_UNITS = 2,
    parameter int GOOD_UNITS    = 12,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_a,
    input  logic              ref_b,
    input  logic              ref_pick,
    input  logic [RSEL_W-1:0] ratio_code,
    output logic              valid_o
);
    localparam int TIMEOUT_CYC = TIMEOUT_UNITS * NOM_CYC;
    localparam int PW          = $clog2(TIMEOUT_CYC + 1);
    localparam int GW          = $clog2(GOOD_UNITS + 1);

    logic [1:0]    ref_raw;
    logic [1:0]    ref_s;
    front_t        front;
    verdict_e      verdict;
    logic [PW-1:0] period_cnt;
    logic [GW-1:0] good_run;

    assign ref_raw = {ref_b, ref_a};

    for (genvar gi = 0; gi < 2; gi++) begin : g_sync
        ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (ref_raw[gi]),
            .q   (ref_s[gi])
        );
    end

    rvm_front #(.RSEL_W(RSEL_W)) u_front (
        .clk        (clk),
        .rst        (rst),
        .ref_s      (ref_s),
        .ref_pick   (ref_pick),
        .ratio_code (ratio_code),
        .front      (front)
    );

    rvm_period #(
        .NOM_CYC       (NOM_CYC),
        .TOL_CYC       (TOL_CYC),
        .TIMEOUT_UNITS (TIMEOUT_UNITS)
    ) u_period (
        .clk        (clk),
        .rst        (rst),
        .front      (front),
        .verdict    (verdict),
        .period_cnt (period_cnt)
    );

    rvm_recovery #(.GOOD_UNITS(GOOD_UNITS)) u_recovery (
        .clk      (clk),
        .rst      (rst),
        .restart  (front.restart),
        .verdict  (verdict),
        .good_run (good_run),
        .valid    (valid_o)
    );
endmodule

// File: rtl/rvm_checker.sv
module rvm_checker import rvm_pkg::*; #(
    parameter int RSEL_W        = 2,
    parameter int NOM_CYC       = 64,
    parameter int TIMEOUT_UNITS = 2,
    parameter int GOOD_UNITS    = 12,
    localparam int TIMEOUT_CYC  = TIMEOUT_UNITS * NOM_CYC,
    localparam int PW           = $clog2(TIMEOUT_CYC + 1),
    localparam int GW           = $clog2(GOOD_UNITS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_pick,
    input logic [RSEL_W-1:0] ratio_code,
    input logic              valid_o,
    input verdict_e          verdict,
    input logic [PW-1:0]     period_cnt,
    input logic [GW-1:0]     good_run
);
    p_reset_low_r2: assert property (@(posedge clk) rst |=> !valid_o);

    p_bad_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (verdict == VD_BAD) |=> !valid_o);

    p_timeout_bound_r5: assert property (@(posedge clk) disable iff (rst)
        period_cnt < PW'(TIMEOUT_CYC));

    p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
        good_run <= GW'(GOOD_UNITS));

    p_rise_after_run_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> ($past(verdict) == VD_GOOD) && ($past(good_run) == GW'(GOOD_UNITS - 1)));

    p_pick_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (ref_pick != $past(ref_pick)) |=> !valid_o);

    p_ratio_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (ratio_code != $past(ratio_code)) |=> !valid_o);
endmodule

bind ref_valid_monitor rvm_checker #(
    .RSEL_W        (RSEL_W),
    .NOM_CYC       (NOM_CYC),
    .TIMEOUT_UNITS (TIMEOUT_UNITS),
    .GOOD_UNITS    (GOOD_UNITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_pick   (ref_pick),
    .ratio_code (ratio_code),
    .valid_o    (valid_o),
    .verdict    (verdict),
    .period_cnt (period_cnt),
    .good_run   (good_run)
);

// File: tb/ref_valid_monitor_bench.sv
`timescale 1ns/1ps
module ref_valid_monitor_bench;
    localparam int NOM = 64;
    localparam int LO  = 60;
    localparam int HI  = 68;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_a = 1'b0;
    logic       ref_b = 1'b0;
    logic       ref_pick = 1'b1;
    logic [1:0] ratio_code = 2'd0;
    logic       valid_o;

    int half_a = 32;
    int half_b = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ref_valid_monitor u_ref_valid_monitor (
        .clk        (clk),
        .rst        (rst),
        .ref_a      (ref_a),
        .ref_b      (ref_b),
        .ref_pick   (ref_pick),
        .ratio_code (ratio_code),
        .valid_o    (valid_o)
    );

    // Reference generators: toggle every half_x local cycles, idle when 0.
    initial begin
        forever begin
            if (half_a == 0) @(negedge clk);
            else begin
                repeat (half_a) @(negedge clk);
                ref_a = ~ref_a;
            end
        end
    end

    initial begin
        forever begin
            if (half_b == 0) @(negedge clk);
            else begin
                repeat (half_b) @(negedge clk);
                ref_b = ~ref_b;
            end
        end
    end

    function automatic bit expect_good(input int code, input int half);
        int unit_len;
        unit_len = 2 * half * (1 << code);
        return (unit_len >= LO) && (unit_len <= HI);
    endfunction

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s valid_o=%0b expected=%0b at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired valid_o=%0b expected=finish", valid_o);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int code;
        int nomh;
        int half;
        int span;
        bit exp_v;
        void'($urandom(32'd4711));

        // Reset state (R2)
        wait_cyc(5);
        check("R2 flag low in reset", valid_o, 1'b0);
        rst = 1'b0;

        // Recovery timing from a clean start (R6, R2)
        wait_cyc(11 * NOM);
        check("R6 not yet valid after 11 units", valid_o, 1'b0);
        wait_cyc(4 * NOM);
        check("R6 valid after 15 units", valid_o, 1'b1);

        // Stopped reference (R5)
        @(posedge ref_a);
        half_a = 0;
        wait_cyc(100);
        check("R5 still valid 100 cycles after last edge", valid_o, 1'b1);
        wait_cyc(45);
        check("R5 low after silence of two units", valid_o, 1'b0);

        // Automatic recovery when the reference returns (R6)
        half_a = 32;
        wait_cyc(16 * NOM);
        check("R6 automatic recovery", valid_o, 1'b1);

        // Drift fails fast (R4)
        half_a = 40;
        wait_cyc(3 * 80);
        check("R4 long units drop flag quickly", valid_o, 1'b0);

        // Window edges with n = 1 (R4)
        half_a = 30;
        wait_cyc(20 * NOM);
        check("R4 unit of 60 cycles is good", valid_o, 1'b1);
        half_a = 34;
        wait_cyc(20 * NOM);
        check("R4 unit of 68 cycles is good", valid_o, 1'b1);
        half_a = 29;
        wait_cyc(20 * NOM);
        check("R4 unit of 58 cycles is bad", valid_o, 1'b0);
        half_a = 35;
        wait_cyc(20 * NOM);
        check("R4 unit of 70 cycles is bad", valid_o, 1'b0);
        half_a = 32;
        wait_cyc(20 * NOM);
        check("R4 nominal after drift recovers", valid_o, 1'b1);

        // Ratio change restarts; n = 8 with a fast reference (R7, R3)
        ratio_code = 2'd3;
        half_a = 4;
        wait_cyc(3);
        check("R7 ratio change clears flag", valid_o, 1'b0);
        wait_cyc(16 * NOM);
        check("R3 n=8 nominal reference valid", valid_o, 1'b1);

        // Select polarity (R1, R7)
        ratio_code = 2'd1;
        half_a = 16;
        half_b = 0;
        wait_cyc(16 * NOM);
        check("R1 ref_a selected when pick=1", valid_o, 1'b1);
        ref_pick = 1'b0;
        wait_cyc(3);
        check("R7 select change clears flag", valid_o, 1'b0);
        wait_cyc(16 * NOM);
        check("R1 dead ref_b selected stays low", valid_o, 1'b0);
        half_b = 16;
        wait_cyc(16 * NOM);
        check("R1 ref_b good when pick=0", valid_o, 1'b1);
        half_a = 0;
        wait_cyc(4 * NOM);
        check("R1 unselected ref_a stop ignored", valid_o, 1'b1);
        half_b = 20;
        wait_cyc(3 * NOM);
        check("R1 drift on selected ref_b seen", valid_o, 1'b0);

        // Random periods and ratios on ref_a (R3, R4)
        ref_pick = 1'b1;
        half_b = 0;
        for (int t = 0; t < 12; t++) begin
            code  = int'($urandom % 4);
            nomh  = 32 >> code;
            half  = nomh - (nomh / 4) + int'($urandom % (2 * (nomh / 4) + 1));
            exp_v = expect_good(code, half);
            ratio_code = 2'(code);
            half_a = half;
            span = 2 * half * (1 << code);
            if (span < NOM) span = NOM;
            wait_cyc(22 * span);
            check($sformatf("R3 R4 random code=%0d half=%0d", code, half), valid_o, exp_v);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule